// File: doc/BRIEF.md
# Demand-Gated Highway/Side-Street Signal Controller

This block sequences the signal heads of a crossing where a main highway meets a minor side street. The highway heads (Z) rest on green. The side-street heads (X) get a green only after a vehicle detector on the side street has asked for one. Phase lengths are counted in one-second ticks that arrive on an enable input. The block needs no slower clock of its own.

Each direction has a pedestrian walk countdown that runs while that direction is green. The two counts leave the block as binary values for a seven-segment display driver, which lives outside this block. Two stop-line detectors on the side street are watched while X is red. A fresh activation on either one fires a one-clock trigger to the enforcement camera assigned to that detector. The six lamp outputs and the two camera triggers share one 10-bit bar-graph bus.

The phases, in order, are:

| Phase | Meaning | Length |
|---|---|---|
| Z_GO | highway green, side street red | at least 20 ticks |
| Z_WARN | highway yellow | 3 ticks |
| Z_CLEAR | all red | 1 tick |
| X_GO | side-street green | 10 ticks |
| X_WARN | side-street yellow | 3 ticks |
| X_CLEAR | all red | 1 tick |

After X_CLEAR the controller returns to Z_GO. The transitions are:

| Transition | Condition |
|---|---|
| Z_GO→Z_WARN | minimum reached, latched demand, and a tick |
| Z_WARN→Z_CLEAR | on the tick that ends the phase |
| Z_CLEAR→X_GO | on the tick that ends the phase |
| X_GO→X_WARN | on the tick that ends the phase |
| X_WARN→X_CLEAR | on the tick that ends the phase |
| X_CLEAR→Z_GO | on the tick that ends the phase |

Top module: `tlc_intersection`

## Requirements
- R1: A synchronous active-high reset places the controller in Z_GO with X red, clears both walk counts to 0, clears the camera triggers and empties the demand latch. With no new demand after reset, Z stays green however many ticks arrive.
- R2: The phases follow the order Z_GO, Z_WARN, Z_CLEAR, X_GO, X_WARN, X_CLEAR, then Z_GO again. Z_WARN lasts 3 ticks, each all-red phase lasts 1 tick, X_GO lasts 10 ticks and X_WARN lasts 3 ticks. The phase changes on the clock edge that samples the tick which ends it. In every phase each head lights exactly one lamp, and the two heads are never green together.
- R3: Z_GO lasts at least 20 ticks. It ends only on a tick at which a demand is latched. Once the minimum has passed, a later demand ends Z_GO on the next tick after the demand is latched.
- R4: A high level on sens_a or on sens_c, sampled while X is red, sets the demand latch. The latch is cleared on the edge that enters X_GO. Sensor activity while X is green or yellow does not set it, so it does not cause another side-street green.
- R5: On the edge that enters a direction's green, that direction's walk count loads 9. It then drops by one on each tick, holds at 0, and reads 0 whenever that direction is not green. A full X_GO therefore shows 9 down to 0.
- R6: A rising edge on sens_d fires camera U, and a rising edge on sens_b fires camera V. The trigger is a one-clock pulse in the clock after the edge is sampled, and it fires only if X was red when the edge was sampled. A sensor held high produces no further pulse. An edge while X is green or yellow produces no pulse.
- R7: Bar bus layout: bit0 Z red, bit1 Z yellow, bit2 Z green, bit3 X red, bit4 X yellow, bit5 X green, bit6 camera U, bit7 camera V, and bits 9:8 always 0. After reset the bus reads 10'h00C.
- R8: Lamp outputs change only on edges where sec_tick is high. With no tick, the phase holds even when a demand is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| sec_tick | input | 1 | one-clock enable, once per second |
| sens_a | input | 1 | side-street demand detector |
| sens_b | input | 1 | stop-line detector feeding camera V |
| sens_c | input | 1 | side-street demand detector |
| sens_d | input | 1 | stop-line detector feeding camera U |
| bar_o | output | 10 | lamps and camera triggers, layout per R7 |
| walk_x | output | 4 | side-street walk count |
| walk_z | output | 4 | highway walk count |

## Verification
The bench builds the block with its default parameters: a 20-tick minimum highway green, 3-tick yellows, 1-tick all-reds, a 10-tick side-street green and a walk start of 9. It pulses sec_tick every second clock, so a whole signal cycle takes under a hundred clocks. That rate is short enough to step tick by tick through every phase boundary and every walk count. It also makes room to hold the highway far past its minimum, which brings within reach both the saturated-timer exit on a late demand and the idle hold with no demand. Camera edges are placed both in a red and in a green side-street phase.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [2:0] {
        Z_GO    = 3'd0,
        Z_WARN  = 3'd1,
        Z_CLEAR = 3'd2,
        X_GO    = 3'd3,
        X_WARN  = 3'd4,
        X_CLEAR = 3'd5
    } phase_t;

    typedef struct packed {
        logic grn;
        logic yel;
        logic red;
    } lamp_t;

    localparam lamp_t LAMP_RED = '{grn: 1'b0, yel: 1'b0, red: 1'b1};
    localparam lamp_t LAMP_YEL = '{grn: 1'b0, yel: 1'b1, red: 1'b0};
    localparam lamp_t LAMP_GRN = '{grn: 1'b1, yel: 1'b0, red: 1'b0};

endpackage

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
    import tlc_pkg::*;
#(
    parameter int ZG_MIN = 20,
    parameter int Z_YEL  = 3,
    parameter int CLR    = 1,
    parameter int X_GRN  = 10,
    parameter int X_YEL  = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   req,
    output phase_t state_q,
    output phase_t state_d,
    output lamp_t  x_lamp,
    output lamp_t  z_lamp
);

    localparam int MAX_A   = (ZG_MIN > X_GRN) ? ZG_MIN : X_GRN;
    localparam int MAX_B   = (Z_YEL > X_YEL) ? Z_YEL : X_YEL;
    localparam int MAX_C   = (MAX_B > CLR) ? MAX_B : CLR;
    localparam int MAX_DUR = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int TMR_W   = $clog2(MAX_DUR + 1);

    localparam logic [TMR_W-1:0] ZG_LAST = TMR_W'(ZG_MIN - 1);
    localparam logic [TMR_W-1:0] ZY_LAST = TMR_W'(Z_YEL - 1);
    localparam logic [TMR_W-1:0] CL_LAST = TMR_W'(CLR - 1);
    localparam logic [TMR_W-1:0] XG_LAST = TMR_W'(X_GRN - 1);
    localparam logic [TMR_W-1:0] XY_LAST = TMR_W'(X_YEL - 1);
    localparam logic [TMR_W-1:0] ONE     = TMR_W'(1);

    logic [TMR_W-1:0] tmr_q, tmr_d;

    // next-state and phase timer
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        if (tick) begin
            unique case (state_q)
                Z_GO: begin
                    if (tmr_q != ZG_LAST) begin
                        tmr_d = tmr_q + ONE;
                    end else if (req) begin
                        state_d = Z_WARN;
                        tmr_d   = '0;
                    end
                end
                Z_WARN: begin
                    if (tmr_q == ZY_LAST) begin
                        state_d = Z_CLEAR;
                        tmr_d   = '0;
                    end else begin
                        tmr_d = tmr_q + ONE;
                    end
                end
                Z_CLEAR: begin
                    if (tmr_q == CL_LAST) begin
                        state_d = X_GO;
                        tmr_d   = '0;
                    end else begin
                        tmr_d = tmr_q + ONE;
                    end
                end
                X_GO: begin
                    if (tmr_q == XG_LAST) begin
                        state_d = X_WARN;
                        tmr_d   = '0;
                    end else begin
                        tmr_d = tmr_q + ONE;
                    end
                end
                X_WARN: begin
                    if (tmr_q == XY_LAST) begin
                        state_d = X_CLEAR;
                        tmr_d   = '0;
                    end else begin
                        tmr_d = tmr_q + ONE;
                    end
                end
                X_CLEAR: begin
                    if (tmr_q == CL_LAST) begin
                        state_d = Z_GO;
                        tmr_d   = '0;
                    end else begin
                        tmr_d = tmr_q + ONE;
                    end
                end
                default: begin
                    state_d = Z_GO;
                    tmr_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= Z_GO;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    // lamp decode
    always_comb begin
        x_lamp = LAMP_RED;
        z_lamp = LAMP_RED;
        unique case (state_q)
            Z_GO:    z_lamp = LAMP_GRN;
            Z_WARN:  z_lamp = LAMP_YEL;
            Z_CLEAR: z_lamp = LAMP_RED;
            X_GO:    x_lamp = LAMP_GRN;
            X_WARN:  x_lamp = LAMP_YEL;
            X_CLEAR: x_lamp = LAMP_RED;
            default: begin
                x_lamp = LAMP_RED;
                z_lamp = LAMP_RED;
            end
        endcase
    end

endmodule

// File: rtl/tlc_req_latch.sv
module tlc_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic sens_a,
    input  logic sens_c,
    input  logic x_red,
    input  logic grant,
    output logic req
);

    always_ff @(posedge clk) begin
        if (rst || grant) begin
            req <= 1'b0;
        end else if ((sens_a || sens_c) && x_red) begin
            req <= 1'b1;
        end
    end

endmodule

// File: rtl/tlc_walk_timer.sv
module tlc_walk_timer #(
    parameter int WALK_W     = 4,
    parameter int WALK_START = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              green_q,
    input  logic              green_d,
    output logic [WALK_W-1:0] count
);

    localparam logic [WALK_W-1:0] START = WALK_W'(WALK_START);
    localparam logic [WALK_W-1:0] ONE   = WALK_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !green_d) begin
            count <= '0;
        end else if (!green_q) begin
            count <= START;
        end else if (tick && (count != '0)) begin
            count <= count - ONE;
        end
    end

endmodule

// File: rtl/tlc_cam_trig.sv
module tlc_cam_trig (
    input  logic clk,
    input  logic rst,
    input  logic sense,
    input  logic armed,
    output logic pulse
);

    logic prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            prev  <= sense;
            pulse <= sense && !prev && armed;
        end
    end

endmodule

// File: rtl/tlc_intersection.sv
module tlc_intersection
    import tlc_pkg::*;
#(
    parameter int ZG_MIN     = 20,
    parameter int Z_YEL      = 3,
    parameter int CLR        = 1,
    parameter int X_GRN      = 10,
    parameter int X_YEL      = 3,
    parameter int WALK_W     = 4,
    parameter int WALK_START = 9,
    parameter int BAR_W      = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              sens_a,
    input  logic              sens_b,
    input  logic              sens_c,
    input  logic              sens_d,
    output logic [BAR_W-1:0]  bar_o,
    output logic [WALK_W-1:0] walk_x,
    output logic [WALK_W-1:0] walk_z
);

    localparam int NDIR  = 2;
    localparam int NCAM  = 2;
    localparam int USED  = 6 + NCAM;

    phase_t state_q, state_d;
    lamp_t  x_lamp, z_lamp;
    logic   req;
    logic   grant;

    logic              green_q  [NDIR];
    logic              green_d  [NDIR];
    logic [WALK_W-1:0] walk_cnt [NDIR];
    logic [NCAM-1:0]   cam_in;
    logic [NCAM-1:0]   cam_out;

    tlc_phase_fsm #(
        .ZG_MIN (ZG_MIN),
        .Z_YEL  (Z_YEL),
        .CLR    (CLR),
        .X_GRN  (X_GRN),
        .X_YEL  (X_YEL)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .tick    (sec_tick),
        .req     (req),
        .state_q (state_q),
        .state_d (state_d),
        .x_lamp  (x_lamp),
        .z_lamp  (z_lamp)
    );

    assign grant = (state_d == X_GO) && (state_q != X_GO);

    tlc_req_latch u_req (
        .clk    (clk),
        .rst    (rst),
        .sens_a (sens_a),
        .sens_c (sens_c),
        .x_red  (x_lamp.red),
        .grant  (grant),
        .req    (req)
    );

    // index 0: side street, index 1: highway
    assign green_q[0] = (state_q == X_GO);
    assign green_d[0] = (state_d == X_GO);
    assign green_q[1] = (state_q == Z_GO);
    assign green_d[1] = (state_d == Z_GO);

    for (genvar i = 0; i < NDIR; i++) begin : g_walk
        tlc_walk_timer #(
            .WALK_W     (WALK_W),
            .WALK_START (WALK_START)
        ) u_walk (
            .clk     (clk),
            .rst     (rst),
            .tick    (sec_tick),
            .green_q (green_q[i]),
            .green_d (green_d[i]),
            .count   (walk_cnt[i])
        );
    end

    assign walk_x = walk_cnt[0];
    assign walk_z = walk_cnt[1];

    // index 0: camera U from sens_d, index 1: camera V from sens_b
    assign cam_in = {sens_b, sens_d};

    for (genvar k = 0; k < NCAM; k++) begin : g_cam
        tlc_cam_trig u_cam (
            .clk   (clk),
            .rst   (rst),
            .sense (cam_in[k]),
            .armed (x_lamp.red),
            .pulse (cam_out[k])
        );
    end

    assign bar_o = {{(BAR_W - USED){1'b0}}, cam_out,
                    x_lamp.grn, x_lamp.yel, x_lamp.red,
                    z_lamp.grn, z_lamp.yel, z_lamp.red};

endmodule

// File: rtl/tlc_intersection_chk.sv
module tlc_intersection_chk #(
    parameter int WALK_W = 4,
    parameter int BAR_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic [BAR_W-1:0]  bar_o,
    input logic [WALK_W-1:0] walk_x,
    input logic [WALK_W-1:0] walk_z
);

    // R8
    lamps_need_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> $stable(bar_o[5:0]));

    // R2
    one_lamp_per_head_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(bar_o[2:0]) == 1) && ($countones(bar_o[5:3]) == 1));

    // R2
    no_dual_green_chk: assert property (@(posedge clk) disable iff (rst)
        !(bar_o[5] && bar_o[2]));

    // R5
    walk_x_in_green_chk: assert property (@(posedge clk) disable iff (rst)
        (walk_x != '0) |-> bar_o[5]);

    // R5
    walk_z_in_green_chk: assert property (@(posedge clk) disable iff (rst)
        (walk_z != '0) |-> bar_o[2]);

    // R6
    cam_u_single_chk: assert property (@(posedge clk) disable iff (rst)
        bar_o[6] |=> !bar_o[6]);

    // R6
    cam_v_single_chk: assert property (@(posedge clk) disable iff (rst)
        bar_o[7] |=> !bar_o[7]);

    // R6
    cam_only_red_chk: assert property (@(posedge clk) disable iff (rst)
        (bar_o[6] || bar_o[7]) |-> $past(bar_o[3]));

endmodule

bind tlc_intersection tlc_intersection_chk #(
    .WALK_W (WALK_W),
    .BAR_W  (BAR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sec_tick (sec_tick),
    .bar_o    (bar_o),
    .walk_x   (walk_x),
    .walk_z   (walk_z)
);

// File: tb/tb_tlc_intersection.sv
module tb_tlc_intersection;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       sens_a = 1'b0;
    logic       sens_b = 1'b0;
    logic       sens_c = 1'b0;
    logic       sens_d = 1'b0;
    logic [9:0] bar_o;
    logic [3:0] walk_x;
    logic [3:0] walk_z;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tlc_intersection dut (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .sens_a   (sens_a),
        .sens_b   (sens_b),
        .sens_c   (sens_c),
        .sens_d   (sens_d),
        .bar_o    (bar_o),
        .walk_x   (walk_x),
        .walk_z   (walk_z)
    );

    // lamp patterns {x_grn,x_yel,x_red,z_grn,z_yel,z_red}
    localparam logic [5:0] L_ZG = 6'b001100;
    localparam logic [5:0] L_ZY = 6'b001010;
    localparam logic [5:0] L_AR = 6'b001001;
    localparam logic [5:0] L_XG = 6'b100001;
    localparam logic [5:0] L_XY = 6'b010001;

    // {ticks to apply, lamps, walk_x, walk_z}
    localparam int NVEC = 13;
    localparam logic [21:0] VEC [NVEC] = '{
        {8'd19, L_ZG, 4'd0, 4'd0},
        {8'd1,  L_ZY, 4'd0, 4'd0},
        {8'd2,  L_ZY, 4'd0, 4'd0},
        {8'd1,  L_AR, 4'd0, 4'd0},
        {8'd1,  L_XG, 4'd9, 4'd0},
        {8'd1,  L_XG, 4'd8, 4'd0},
        {8'd8,  L_XG, 4'd0, 4'd0},
        {8'd1,  L_XY, 4'd0, 4'd0},
        {8'd2,  L_XY, 4'd0, 4'd0},
        {8'd1,  L_AR, 4'd0, 4'd0},
        {8'd1,  L_ZG, 4'd0, 4'd9},
        {8'd1,  L_ZG, 4'd0, 4'd8},
        {8'd25, L_ZG, 4'd0, 4'd0}
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sec_tick = 1'b1;
            @(negedge clk) sec_tick = 1'b0;
        end
    endtask

    task automatic pulse_a();
        @(negedge clk) sens_a = 1'b1;
        @(negedge clk) sens_a = 1'b0;
    endtask

    task automatic pulse_c();
        @(negedge clk) sens_c = 1'b1;
        @(negedge clk) sens_c = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 R7: reset state and bus layout
        check("R1", "bar after reset", int'(bar_o), 12);
        check("R7", "spare bits", int'(bar_o[9:8]), 0);
        check("R1", "walk_x after reset", int'(walk_x), 0);
        check("R1", "walk_z after reset", int'(walk_z), 0);

        // R4: demand from sens_a during Z_GO
        pulse_a();
        for (int v = 0; v < NVEC; v++) begin
            do_ticks(int'(VEC[v][21:14]));
            check("R2", $sformatf("lamps vec %0d", v), int'(bar_o[5:0]), int'(VEC[v][13:8]));
            check("R5", $sformatf("walk_x vec %0d", v), int'(walk_x), int'(VEC[v][7:4]));
            check("R5", $sformatf("walk_z vec %0d", v), int'(walk_z), int'(VEC[v][3:0]));
        end
        // R3: no demand, still holding Z green well past the minimum
        check("R3", "hold without demand", int'(bar_o[5:0]), int'(L_ZG));

        // R3 R4: late demand from sens_c leaves at once
        pulse_c();
        do_ticks(1);
        check("R3", "late demand exit", int'(bar_o[5:0]), int'(L_ZY));
        do_ticks(4);
        check("R4", "granted green", int'(bar_o[5:0]), int'(L_XG));

        // R4: demand while X green is ignored
        pulse_a();
        // R6: stop-line edge while X green gives no pulse
        @(negedge clk) sens_b = 1'b1;
        @(negedge clk) check("R6", "cam V in green", int'(bar_o[7]), 0);
        @(negedge clk) check("R6", "cam V in green later", int'(bar_o[7]), 0);
        sens_b = 1'b0;
        do_ticks(14);
        check("R2", "back to Z green", int'(bar_o[5:0]), int'(L_ZG));
        do_ticks(21);
        check("R4", "ignored demand", int'(bar_o[5:0]), int'(L_ZG));

        // R6: camera U on sens_d rising while X red
        @(negedge clk) sens_d = 1'b1;
        @(negedge clk) begin
            check("R6", "cam U pulse", int'(bar_o[6]), 1);
            check("R6", "cam V quiet", int'(bar_o[7]), 0);
        end
        @(negedge clk) check("R6", "cam U one clock", int'(bar_o[6]), 0);
        @(negedge clk) check("R6", "cam U held sensor", int'(bar_o[6]), 0);
        sens_d = 1'b0;
        // R6: camera V on sens_b rising while X red
        @(negedge clk) sens_b = 1'b1;
        @(negedge clk) begin
            check("R6", "cam V pulse", int'(bar_o[7]), 1);
            check("R6", "cam U quiet", int'(bar_o[6]), 0);
        end
        @(negedge clk) check("R6", "cam V one clock", int'(bar_o[7]), 0);
        sens_b = 1'b0;

        // R8: pending demand but no tick
        pulse_a();
        repeat (50) @(negedge clk);
        check("R8", "hold without tick", int'(bar_o[5:0]), int'(L_ZG));
        do_ticks(1);
        check("R8", "move on tick", int'(bar_o[5:0]), int'(L_ZY));

        // R1: reset in the middle of X green
        do_ticks(4);
        check("R5", "walk_x at X entry", int'(walk_x), 9);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R1", "bar after mid reset", int'(bar_o), 12);
        check("R1", "walk_x after mid reset", int'(walk_x), 0);
        check("R1", "walk_z after mid reset", int'(walk_z), 0);
        do_ticks(25);
        check("R1", "latch empty after reset", int'(bar_o[5:0]), int'(L_ZG));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule